// File: doc/BRIEF.md
# Erase-Before-Write Wiper Setting Store

This block holds the saved settings of a four-channel digital wiper: four 9-bit words per channel, sixteen in all, plus the live wiper register (8 bits) and output-mode bit of each channel. A word is written in two steps. An erase access sets every bit of the word to one. A later program access can only clear bits, because it ANDs the supplied data into the word. A word that was not erased first therefore ends up holding a mix of the old and new values. Read accesses return a word. Load accesses copy a word into one channel's wiper and mode bit. Recall accesses copy location 0 of every channel into all wipers in a single step.

Accesses use a request/done handshake. The block accepts a request only while it is idle. It then holds `busy` for a set number of cycles: a long count for erase and program, a short count for read, load and recall. At the end it commits the result and pulses `done` for one cycle. An active-low write-protect input stops erase and program from changing the array, but reads, loads and recalls still work. Leaving reset works like power-up. Reset puts the array in the erased state, then the block runs a recall access, so every wiper takes the value of its channel's location 0.

Top module: `nv_word_store`

## Requirements
- R1: During reset and right after it, `busy` is 1 and all wipers and mode bits are 0. Reset leaves every word erased (9'h1FF). After `SHORT_CYC` cycles `done` pulses and each channel holds wiper 8'hFF and mode 1.
- R2: Erase (opcode 4'b1101) sets the addressed word to 9'h1FF. The word index is `chan*4 + loc`.
- R3: Program (opcode 4'b0010) on an erased word stores `req_data` exactly.
- R4: Program on a word that is not erased stores the bitwise AND of the old word and `req_data`.
- R5: While `wp_n` is 0 when a request is accepted, erase and program leave the array unchanged. They still run their full busy time and pulse `done`.
- R6: Read (opcode 4'b1010) places the addressed word on `rd_data` at the cycle `done` rises. `rd_data` changes at no other time.
- R7: Load (opcode 4'b1011) copies bits 7:0 of the addressed word to that channel's wiper and bit 8 to its mode bit. Write-protect does not affect it.
- R8: Recall (opcode 4'b1001) copies location 0 of every channel into all wipers and mode bits at once. Write-protect does not affect it.
- R9: A request sampled at clock edge k makes `done` high in the cycle after edge k+`LONG_CYC` for erase and program, and after edge k+`SHORT_CYC` for read, load and recall.
- R10: A request that arrives while `busy` is 1 is ignored. It changes nothing and does not shorten or extend the running access.
- R11: `done` is high for exactly one cycle and never together with `busy`. Wipers change only in a cycle where `done` is high.
- R12: A request with any other opcode is ignored: `busy` stays 0, `done` does not pulse and nothing changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; release acts as power-up |
| req_valid | input | 1 | Request strobe, sampled while idle |
| req_op | input | 4 | Access opcode |
| req_chan | input | 2 | Channel field |
| req_loc | input | 2 | Location field within the channel |
| req_data | input | 9 | Program data |
| wp_n | input | 1 | Write protect, active low |
| busy | output | 1 | Access in progress |
| done | output | 1 | One-cycle completion pulse |
| rd_data | output | 9 | Last word read |
| wiper | output | 32 | Wiper registers, channel c at bits 8c+7:8c |
| mode | output | 4 | Output-mode bit of each channel |

## Verification
The hardest case to reach from the ports is a request that lands in the middle of a long access. The bench drives a program request with all-zero data to a second word partway through an erase of the first word. It then reads the second word back to confirm the value is still 9'h1FF, and it checks that the erase finished after exactly its own cycle count. A second hard case is a program on an already programmed word. This is set up by programming the same word twice without an erase in between, and the read-back must show the AND of the two values. The write-protect case relies on loads and recalls to show that protected words still move into the wipers.

// File: rtl/nvs_pkg.sv
package nvs_pkg;
    localparam int WORD_W = 9;
    localparam int TAP_W  = 8;

    localparam logic [3:0] OP_PROG   = 4'b0010;
    localparam logic [3:0] OP_RECALL = 4'b1001;
    localparam logic [3:0] OP_READ   = 4'b1010;
    localparam logic [3:0] OP_LOAD   = 4'b1011;
    localparam logic [3:0] OP_ERASE  = 4'b1101;

    function automatic logic op_known(input logic [3:0] op);
        return (op == OP_PROG) || (op == OP_RECALL) || (op == OP_READ) ||
               (op == OP_LOAD) || (op == OP_ERASE);
    endfunction

    function automatic logic op_long(input logic [3:0] op);
        return (op == OP_PROG) || (op == OP_ERASE);
    endfunction
endpackage

// File: rtl/nvs_timer.sv
module nvs_timer #(
    parameter int CW      = 8,
    parameter int RST_CNT = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [CW-1:0] load,
    output logic          busy,
    output logic          expire
);
    typedef struct packed {
        logic          run;
        logic [CW-1:0] cnt;
    } tmr_t;

    tmr_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (s_q.run) begin
            if (s_q.cnt == '0) s_d.run = 1'b0;
            else               s_d.cnt = s_q.cnt - 1'b1;
        end else if (start) begin
            s_d.run = 1'b1;
            s_d.cnt = load;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.run <= 1'b1;
            s_q.cnt <= CW'(RST_CNT);
        end else begin
            s_q <= s_d;
        end
    end

    assign busy   = s_q.run;
    assign expire = s_q.run && (s_q.cnt == '0);
endmodule

// File: rtl/nvs_array.sv
module nvs_array #(
    parameter int NW = 16,
    parameter int WW = 9,
    localparam int IW = $clog2(NW)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             wr_erase,
    input  logic [IW-1:0]    wr_idx,
    input  logic [WW-1:0]    wr_data,
    input  logic [IW-1:0]    rd_idx,
    output logic [WW-1:0]    rd_word,
    output logic [NW*WW-1:0] all_words
);
    logic [NW-1:0][WW-1:0] mem_d, mem_q;

    always_comb begin
        mem_d = mem_q;
        if (wr_en) begin
            if (wr_erase) mem_d[wr_idx] = '1;
            else          mem_d[wr_idx] = mem_q[wr_idx] & wr_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mem_q <= '1;
        else        mem_q <= mem_d;
    end

    assign rd_word = mem_q[rd_idx];

    for (genvar w = 0; w < NW; w++) begin : g_flat
        assign all_words[w*WW +: WW] = mem_q[w];
    end
endmodule

// File: rtl/nv_word_store.sv
module nv_word_store #(
    parameter int NCH       = 4,
    parameter int NLOC      = 4,
    parameter int LONG_CYC  = 40,
    parameter int SHORT_CYC = 3,
    localparam int WW   = nvs_pkg::WORD_W,
    localparam int TW   = nvs_pkg::TAP_W,
    localparam int CHW  = $clog2(NCH),
    localparam int LCW  = $clog2(NLOC),
    localparam int NW   = NCH * NLOC,
    localparam int IW   = $clog2(NW),
    localparam int MAXC = (LONG_CYC > SHORT_CYC) ? LONG_CYC : SHORT_CYC,
    localparam int CW   = $clog2(MAXC + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [3:0]        req_op,
    input  logic [CHW-1:0]    req_chan,
    input  logic [LCW-1:0]    req_loc,
    input  logic [WW-1:0]     req_data,
    input  logic              wp_n,
    output logic              busy,
    output logic              done,
    output logic [WW-1:0]     rd_data,
    output logic [NCH*TW-1:0] wiper,
    output logic [NCH-1:0]    mode
);
    import nvs_pkg::*;

    typedef struct packed {
        logic [3:0]            op;
        logic [CHW-1:0]        chan;
        logic [IW-1:0]         idx;
        logic [WW-1:0]         data;
        logic                  wp;
        logic                  done;
        logic [WW-1:0]         rd;
        logic [NCH-1:0][TW-1:0] wip;
        logic [NCH-1:0]        mode;
    } top_t;

    top_t s_d, s_q;

    logic          t_busy, t_expire, accept;
    logic [CW-1:0] t_load;
    logic          a_wr;
    logic [WW-1:0] a_rd;
    logic [NW*WW-1:0] a_all;

    assign accept = req_valid && !t_busy && op_known(req_op);
    assign t_load = op_long(req_op) ? CW'(LONG_CYC - 1) : CW'(SHORT_CYC - 1);
    assign a_wr   = t_expire && s_q.wp && op_long(s_q.op);

    nvs_timer #(.CW(CW), .RST_CNT(SHORT_CYC - 1)) u_tmr (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (accept),
        .load   (t_load),
        .busy   (t_busy),
        .expire (t_expire)
    );

    nvs_array #(.NW(NW), .WW(WW)) u_arr (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (a_wr),
        .wr_erase  (s_q.op == OP_ERASE),
        .wr_idx    (s_q.idx),
        .wr_data   (s_q.data),
        .rd_idx    (s_q.idx),
        .rd_word   (a_rd),
        .all_words (a_all)
    );

    always_comb begin
        s_d      = s_q;
        s_d.done = t_expire;
        if (accept) begin
            s_d.op   = req_op;
            s_d.chan = req_chan;
            s_d.idx  = IW'({req_chan, req_loc});
            s_d.data = req_data;
            s_d.wp   = wp_n;
        end
        if (t_expire) begin
            if (s_q.op == OP_READ) s_d.rd = a_rd;
            if (s_q.op == OP_LOAD) begin
                s_d.wip[s_q.chan]  = a_rd[TW-1:0];
                s_d.mode[s_q.chan] = a_rd[TW];
            end
            if (s_q.op == OP_RECALL) begin
                for (int c = 0; c < NCH; c++) begin
                    s_d.wip[c]  = a_all[(c*NLOC)*WW +: TW];
                    s_d.mode[c] = a_all[(c*NLOC)*WW + TW];
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q      <= '0;
            s_q.op   <= OP_RECALL;
            s_q.wp   <= 1'b1;
        end else begin
            s_q <= s_d;
        end
    end

    assign busy    = t_busy;
    assign done    = s_q.done;
    assign rd_data = s_q.rd;
    assign wiper   = s_q.wip;
    assign mode    = s_q.mode;
endmodule

// File: rtl/nv_word_store_chk.sv
module nv_word_store_chk #(
    parameter int NCH = 4,
    parameter int WW  = 9,
    parameter int TW  = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              busy,
    input logic              done,
    input logic [WW-1:0]     rd_data,
    input logic [NCH*TW-1:0] wiper,
    input logic [NCH-1:0]    mode
);
    assert_done_single_R11: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_done_not_busy_R11: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    assert_busy_from_request_R12: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(req_valid));

    assert_wiper_at_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(wiper) |-> done);

    assert_mode_at_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(mode) |-> done);

    assert_read_at_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(rd_data) |-> done);
endmodule

bind nv_word_store nv_word_store_chk #(.NCH(NCH), .WW(WW), .TW(TW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .busy      (busy),
    .done      (done),
    .rd_data   (rd_data),
    .wiper     (wiper),
    .mode      (mode)
);

// File: tb/tb_nv_word_store.sv
module tb_nv_word_store;
    localparam int LONG  = 40;
    localparam int SHORT = 3;

    logic       clk = 0;
    logic       rst_n = 0;
    logic       req_valid = 0;
    logic [3:0] req_op = 0;
    logic [1:0] req_chan = 0, req_loc = 0;
    logic [8:0] req_data = 0;
    logic       wp_n = 1;
    logic       busy, done;
    logic [8:0] rd_data;
    logic [31:0] wiper;
    logic [3:0]  mode;

    int total = 0, bad = 0;
    logic [8:0] exp_mem [16];

    nv_word_store #(.LONG_CYC(LONG), .SHORT_CYC(SHORT)) dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
        .req_chan(req_chan), .req_loc(req_loc), .req_data(req_data), .wp_n(wp_n),
        .busy(busy), .done(done), .rd_data(rd_data), .wiper(wiper), .mode(mode)
    );

    always #2 clk = ~clk;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wait_done(output int n);
        n = 0;
        while (!done && n < 1000) begin
            @(posedge clk); @(negedge clk); n++;
        end
    endtask

    task automatic run_op(input logic [3:0] op, input int ch, input int loc,
                          input logic [8:0] d, output int n);
        req_op = op; req_chan = 2'(ch); req_loc = 2'(loc); req_data = d;
        req_valid = 1;
        @(posedge clk); @(negedge clk);
        req_valid = 0;
        wait_done(n);
        n++;
    endtask

    task automatic read_chk(input string req, input int ch, input int loc);
        int n;
        run_op(4'b1010, ch, loc, 9'h0, n);
        check({req, " read cycles R9"}, 32'(n), 32'(SHORT + 1));
        check(req, 32'(rd_data), 32'(exp_mem[ch*4+loc]));
        @(negedge clk);
        check("done one cycle R11", 32'(done), 0);
    endtask

    task automatic t_reset;
        check("R1 busy after reset", 32'(busy), 1);
        check("R1 wiper cleared", wiper, 0);
        check("R1 mode cleared", 32'(mode), 0);
    endtask

    task automatic t_power_recall;
        int n;
        rst_n = 1;
        wait_done(n);
        check("R1 recall cycles", 32'(n), 32'(SHORT));
        check("R1 recall wipers", wiper, 32'hFFFF_FFFF);
        check("R1 recall modes", 32'(mode), 32'hF);
        check("R11 not busy at done", 32'(busy), 0);
        @(negedge clk);
    endtask

    task automatic t_erase_program;
        int n;
        run_op(4'b0010, 1, 2, 9'h0A5, n);
        exp_mem[6] = 9'h0A5;
        check("R9 program long", 32'(n), 32'(LONG + 1));
        read_chk("R3 program erased word", 1, 2);
        run_op(4'b0010, 1, 2, 9'h13C, n);
        exp_mem[6] = 9'h0A5 & 9'h13C;
        read_chk("R4 program unerased word", 1, 2);
        run_op(4'b1101, 1, 2, 9'h0, n);
        exp_mem[6] = 9'h1FF;
        check("R9 erase long", 32'(n), 32'(LONG + 1));
        read_chk("R2 erase", 1, 2);
        run_op(4'b0010, 3, 3, 9'h155, n);
        exp_mem[15] = 9'h155;
        read_chk("R3 program index chan*4+loc", 3, 3);
        read_chk("R2 neighbour untouched", 3, 2);
    endtask

    task automatic t_load_recall;
        int n;
        run_op(4'b0010, 2, 1, 9'h05A, n);
        exp_mem[9] = 9'h05A;
        run_op(4'b1011, 2, 1, 9'h0, n);
        check("R9 load short", 32'(n), 32'(SHORT + 1));
        check("R7 load wiper", 32'(wiper[23:16]), 32'h5A);
        check("R7 load mode", 32'(mode[2]), 0);
        check("R7 other wiper", 32'(wiper[7:0]), 32'hFF);
        run_op(4'b0010, 0, 0, 9'h012, n);
        run_op(4'b0010, 3, 0, 9'h1C3, n);
        exp_mem[0] = 9'h012; exp_mem[12] = 9'h1C3;
        run_op(4'b1001, 0, 0, 9'h0, n);
        check("R9 recall short", 32'(n), 32'(SHORT + 1));
        check("R8 recall wipers", wiper, 32'hC3FF_FF12);
        check("R8 recall modes", 32'(mode), 32'b1110);
    endtask

    task automatic t_protect;
        int n;
        wp_n = 0;
        run_op(4'b1101, 0, 0, 9'h0, n);
        check("R5 protected erase still long", 32'(n), 32'(LONG + 1));
        run_op(4'b0010, 1, 1, 9'h000, n);
        check("R5 protected program still long", 32'(n), 32'(LONG + 1));
        read_chk("R5 erase blocked", 0, 0);
        read_chk("R5 program blocked", 1, 1);
        run_op(4'b1011, 3, 0, 9'h0, n);
        check("R7 load under protect", 32'(wiper[31:24]), 32'hC3);
        check("R7 load mode under protect", 32'(mode[3]), 1);
        run_op(4'b1011, 0, 1, 9'h0, n);
        check("R7 load loc1 under protect", 32'(wiper[7:0]), 32'hFF);
        run_op(4'b1001, 0, 0, 9'h0, n);
        check("R8 recall under protect", 32'(wiper[7:0]), 32'h12);
        wp_n = 1;
    endtask

    task automatic t_busy_ignore;
        int n;
        req_op = 4'b1101; req_chan = 2; req_loc = 3; req_valid = 1;
        @(posedge clk); @(negedge clk);
        req_valid = 0;
        repeat (5) @(negedge clk);
        req_op = 4'b0010; req_chan = 2; req_loc = 2; req_data = 9'h000; req_valid = 1;
        @(negedge clk);
        req_valid = 0;
        wait_done(n);
        check("R10 running access length kept", 32'(n + 7), 32'(LONG + 1));
        @(negedge clk);
        check("R10 no second access", 32'(busy), 0);
        read_chk("R10 ignored program", 2, 2);
    endtask

    task automatic t_unknown;
        logic [31:0] w0;
        w0 = wiper;
        req_op = 4'b0000; req_chan = 0; req_loc = 0; req_data = 0; req_valid = 1;
        @(negedge clk);
        req_op = 4'b1111; 
        @(negedge clk);
        req_valid = 0;
        check("R12 unknown no busy", 32'(busy), 0);
        repeat (LONG + 3) begin
            @(negedge clk);
            if (done) check("R12 unknown no done", 32'(done), 0);
        end
        check("R12 wiper unchanged", wiper, w0);
        read_chk("R12 word unchanged", 0, 0);
    endtask

    initial begin
        for (int i = 0; i < 16; i++) exp_mem[i] = 9'h1FF;
        repeat (3) @(negedge clk);
        t_reset();
        t_power_recall();
        t_erase_program();
        t_load_recall();
        t_protect();
        t_busy_ignore();
        t_unknown();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #300000;
        total++; bad++;
        $display("FAIL watchdog R9 actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule